// File: doc/BRIEF.md
# Interlaced Video Timing Pulse Generator

This block produces the auxiliary timing strobes that travel alongside a 4:2:2 digital video stream decoded from an interlaced 525-line or 625-line source. It keeps a pixel counter, a line counter and a quarter-line sub-counter, all aligned to frame position zero when reset is released. From these counters it derives a data-enable window, a horizontal sync pulse, a vertical sync pulse, a field identifier, a Cb/Cr phase flag and a registered copy of an external no-signal indication. The position, width and polarity of the horizontal pulse are set in whole pixels. The vertical pulse is placed and sized in quarter-line steps.

A six-state vertical region machine tracks where the current line sits in the frame. Its states are F1_TOP (field 1 blanking before the picture), F1_ACT (field 1 picture lines), F1_BOT (field 1 blanking after the picture), F2_TOP, F2_ACT and F2_BOT (the same three regions for field 2). Transitions happen only at the last pixel of a line and depend on the number of the next line. The five transitions are: F1_TOP→F1_ACT on entering the first picture line of field 1, F1_ACT→F1_BOT on entering the first line after that picture, F1_BOT→F2_TOP on entering the first line of field 2, F2_TOP→F2_ACT on entering the first picture line of field 2, and F2_ACT→F2_BOT on entering the first line after that picture. A sixth transition, F2_BOT→F1_TOP, fires on the wrap to line 0.

All pulses are captured in one register stage. A per-pin 3-bit code then steers any pulse, or a constant level, onto each of six output pins.

Top module: `vtg_top`

## Requirements
- R1: While reset is held, every pin whose select code is 7 reads 1 and every other pin reads 0. After reset the pixel counter runs 0..H525-1 (std_625=0) or 0..H625-1 (std_625=1), and the line counter runs 0..524 or 0..624. Both wrap back to frame position 0.
- R2: DE is high only when the pixel index lies in [HACT_START, HACT_START+HACT_LEN) and the line lies in a picture window. In 525 mode the windows are lines 20..259 and 283..522. In 625 mode they are lines 23..310 and 336..623. This gives 240 or 288 DE lines per field.
- R3: HD is active for hd_width pixels starting at pixel hd_phase, and wraps past the end of the line. hd_pol=1 inverts the pin level.
- R4: The quarter-line position is q = 4*line + floor(pixel/(H/4)). VD is active for a span of quarters that starts at vd_phase and again at vd_phase plus half a frame (1050 quarters in 525 mode, 1250 in 625 mode). The span wraps at 4*lines-per-frame.
- R5: With vd_width=0, the VD span is 12 quarters (3 lines) in 525 mode and 10 quarters (2.5 lines) in 625 mode. Any other value gives that many quarters. vd_pol=1 inverts the pin level.
- R6: The field pulse is low in field 1 and high in field 2. Field 2 starts at line 263 (525 mode) or line 313 (625 mode). fld_inv=1 inverts it.
- R7: The Cb/Cr flag is high on pixels where (pixel - HACT_START) is even, marking Cb samples, and low on Cr samples. cbcr_inv=1 inverts it.
- R8: The no-signal pulse equals nosig_in as sampled at the previous clock edge.
- R9: Pin i is steered by pin_sel[3i+2:3i]. The codes are 0 = low, 1 = DE, 2 = HD, 3 = VD, 4 = field, 5 = Cb/Cr, 6 = no-signal, 7 = high. After a clock edge, a pin shows the pulse value that belongs to the counter position held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts the frame at position 0 |
| std_625 | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| hd_phase | input | HW | HD start pixel |
| hd_width | input | HW | HD width in pixels |
| hd_pol | input | 1 | HD output inversion |
| vd_phase | input | 12 | VD start position in quarter lines from frame start |
| vd_width | input | VDW | VD width in quarter lines; 0 selects the standard width |
| vd_pol | input | 1 | VD output inversion |
| fld_inv | input | 1 | Field output inversion |
| cbcr_inv | input | 1 | Cb/Cr flag inversion |
| nosig_in | input | 1 | No-signal indication from the detector |
| pin_sel | input | 3*NPINS | Per-pin 3-bit pulse select codes |
| pin_out | output | NPINS | Routed timing pulse pins |

## Verification
The bench builds the block with 16-pixel lines in 525 mode and 20-pixel lines in 625 mode, and places an 8-pixel active window at pixel 4. With these lengths, a full interlaced frame in either standard takes roughly ten thousand cycles. Every pixel of several complete frames, plus the wrap into the next frame, is then compared against a closed-form model for all six pins. The quarter-line divisor stays non-trivial (4 and 5 pixels), so VD phases that land mid-line, VD spans that cross the frame wrap, and HD pulses that cross the line wrap can all be checked cycle by cycle. Picture-line counts and VD duration are also tallied per frame for both standards, with polarity inverted.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int VW  = 10;   // line counter width (up to 625 lines)
    localparam int QPW = 12;   // quarter-line frame position width

    typedef enum logic [2:0] {
        F1_TOP = 3'd0,
        F1_ACT = 3'd1,
        F1_BOT = 3'd2,
        F2_TOP = 3'd3,
        F2_ACT = 3'd4,
        F2_BOT = 3'd5
    } vstate_t;

    localparam logic [2:0] B_ACT1_ON  = 3'd0;
    localparam logic [2:0] B_ACT1_OFF = 3'd1;
    localparam logic [2:0] B_FLD2     = 3'd2;
    localparam logic [2:0] B_ACT2_ON  = 3'd3;
    localparam logic [2:0] B_ACT2_OFF = 3'd4;

    // Line numbers (from frame start) at which a vertical region begins.
    function automatic logic [VW-1:0] vbound(input logic is625, input logic [2:0] idx);
        logic [VW-1:0] r;
        unique case (idx)
            B_ACT1_ON:  r = is625 ? 10'd23  : 10'd20;
            B_ACT1_OFF: r = is625 ? 10'd311 : 10'd260;
            B_FLD2:     r = is625 ? 10'd313 : 10'd263;
            B_ACT2_ON:  r = is625 ? 10'd336 : 10'd283;
            B_ACT2_OFF: r = is625 ? 10'd624 : 10'd523;
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vtg_counters.sv
module vtg_counters #(
    parameter int H525 = 1716,
    parameter int H625 = 1728,
    localparam int HMAX = (H525 > H625) ? H525 : H625,
    localparam int HW   = $clog2(HMAX),
    localparam int QW   = $clog2(HMAX / 4)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   std_625,
    output logic [HW-1:0]          h_cnt,
    output logic [vtg_pkg::VW-1:0] v_cnt,
    output logic [QW-1:0]          qsub,
    output logic [1:0]             qidx,
    output logic                   line_end,
    output logic [vtg_pkg::VW-1:0] next_line
);
    import vtg_pkg::*;

    localparam logic [HW-1:0] H5_LAST = HW'(H525 - 1);
    localparam logic [HW-1:0] H6_LAST = HW'(H625 - 1);
    localparam logic [QW-1:0] Q5_LAST = QW'(H525 / 4 - 1);
    localparam logic [QW-1:0] Q6_LAST = QW'(H625 / 4 - 1);

    logic [HW-1:0] h_last;
    logic [QW-1:0] q_last;
    logic [VW-1:0] v_last;

    assign h_last    = std_625 ? H6_LAST : H5_LAST;
    assign q_last    = std_625 ? Q6_LAST : Q5_LAST;
    assign v_last    = std_625 ? 10'd624 : 10'd524;
    assign line_end  = (h_cnt == h_last);
    assign next_line = (v_cnt == v_last) ? '0 : v_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
            qsub  <= '0;
            qidx  <= '0;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= next_line;
            qsub  <= '0;
            qidx  <= '0;
        end else begin
            h_cnt <= h_cnt + 1'b1;
            if (qsub == q_last) begin
                qsub <= '0;
                qidx <= qidx + 1'b1;
            end else begin
                qsub <= qsub + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vtg_field_fsm.sv
module vtg_field_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   std_625,
    input  logic                   line_end,
    input  logic [vtg_pkg::VW-1:0] next_line,
    output vtg_pkg::vstate_t       state,
    output logic                   v_act,
    output logic                   field
);
    import vtg_pkg::*;

    vstate_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= F1_TOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (line_end) begin
            unique case (state_q)
                F1_TOP:  if (next_line == vbound(std_625, B_ACT1_ON))  state_d = F1_ACT;
                F1_ACT:  if (next_line == vbound(std_625, B_ACT1_OFF)) state_d = F1_BOT;
                F1_BOT:  if (next_line == vbound(std_625, B_FLD2))     state_d = F2_TOP;
                F2_TOP:  if (next_line == vbound(std_625, B_ACT2_ON))  state_d = F2_ACT;
                F2_ACT:  if (next_line == vbound(std_625, B_ACT2_OFF)) state_d = F2_BOT;
                F2_BOT:  if (next_line == '0)                          state_d = F1_TOP;
                default: state_d = F1_TOP;
            endcase
        end
    end

    always_comb begin
        v_act = 1'b0;
        field = 1'b0;
        unique case (state_q)
            F1_ACT:         v_act = 1'b1;
            F2_TOP, F2_BOT: field = 1'b1;
            F2_ACT: begin
                v_act = 1'b1;
                field = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/vtg_pulses.sv
module vtg_pulses #(
    parameter int H525       = 1716,
    parameter int H625       = 1728,
    parameter int HACT_START = 264,
    parameter int HACT_LEN   = 1440,
    parameter int VDW        = 6,
    localparam int HMAX = (H525 > H625) ? H525 : H625,
    localparam int HW   = $clog2(HMAX)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    std_625,
    input  logic [HW-1:0]           h_cnt,
    input  logic [vtg_pkg::VW-1:0]  v_cnt,
    input  logic [1:0]              qidx,
    input  logic                    v_act,
    input  logic                    field,
    input  logic [HW-1:0]           hd_phase,
    input  logic [HW-1:0]           hd_width,
    input  logic                    hd_pol,
    input  logic [vtg_pkg::QPW-1:0] vd_phase,
    input  logic [VDW-1:0]          vd_width,
    input  logic                    vd_pol,
    input  logic                    fld_inv,
    input  logic                    cbcr_inv,
    input  logic                    nosig_in,
    output logic [7:0]              pulse_q
);
    import vtg_pkg::*;

    localparam logic [HW:0]   HT5   = (HW+1)'(H525);
    localparam logic [HW:0]   HT6   = (HW+1)'(H625);
    localparam logic [HW-1:0] HA_LO = HW'(HACT_START);
    localparam logic [HW-1:0] HA_HI = HW'(HACT_START + HACT_LEN);

    logic [HW:0]    ht, h_e, hp_e, hrel;
    logic [QPW:0]   frameq, halfq, qpos_e, ph_e, qrel, vw_e;
    logic [VDW-1:0] vw;
    logic [HW-1:0]  hoff;
    logic           hd_on, vd_on, de_on, cb_on;

    always_comb begin
        ht   = std_625 ? HT6 : HT5;
        h_e  = {1'b0, h_cnt};
        hp_e = {1'b0, hd_phase};
        hrel = (h_e >= hp_e) ? h_e - hp_e : h_e + ht - hp_e;
        hd_on = (hrel < {1'b0, hd_width});

        frameq = std_625 ? 13'd2500 : 13'd2100;
        halfq  = std_625 ? 13'd1250 : 13'd1050;
        qpos_e = {1'b0, v_cnt, qidx};
        ph_e   = {1'b0, vd_phase};
        qrel   = (qpos_e >= ph_e) ? qpos_e - ph_e : qpos_e + frameq - ph_e;
        vw     = (vd_width == '0) ? (std_625 ? VDW'(10) : VDW'(12)) : vd_width;
        vw_e   = (QPW+1)'(vw);
        vd_on  = (qrel < vw_e) || ((qrel >= halfq) && (qrel < halfq + vw_e));

        de_on = v_act && (h_cnt >= HA_LO) && (h_cnt < HA_HI);
        hoff  = h_cnt - HA_LO;
        cb_on = ~hoff[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 8'h80;
        else        pulse_q <= {1'b1, nosig_in, cb_on ^ cbcr_inv, field ^ fld_inv,
                                vd_on ^ vd_pol, hd_on ^ hd_pol, de_on, 1'b0};
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
    parameter int H525       = 1716,
    parameter int H625       = 1728,
    parameter int HACT_START = 264,
    parameter int HACT_LEN   = 1440,
    parameter int VDW        = 6,
    parameter int NPINS      = 6,
    localparam int HMAX = (H525 > H625) ? H525 : H625,
    localparam int HW   = $clog2(HMAX),
    localparam int QW   = $clog2(HMAX / 4)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    std_625,
    input  logic [HW-1:0]           hd_phase,
    input  logic [HW-1:0]           hd_width,
    input  logic                    hd_pol,
    input  logic [vtg_pkg::QPW-1:0] vd_phase,
    input  logic [VDW-1:0]          vd_width,
    input  logic                    vd_pol,
    input  logic                    fld_inv,
    input  logic                    cbcr_inv,
    input  logic                    nosig_in,
    input  logic [3*NPINS-1:0]      pin_sel,
    output logic [NPINS-1:0]        pin_out
);
    import vtg_pkg::*;

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt, next_line;
    logic [QW-1:0] qsub;
    logic [1:0]    qidx;
    logic          line_end, v_act, field;
    vstate_t       state;
    logic [7:0]    pulse_q;

    vtg_counters #(.H525(H525), .H625(H625)) u_cnt (
        .clk(clk), .rst_n(rst_n), .std_625(std_625),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .qsub(qsub), .qidx(qidx),
        .line_end(line_end), .next_line(next_line)
    );

    vtg_field_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .std_625(std_625),
        .line_end(line_end), .next_line(next_line),
        .state(state), .v_act(v_act), .field(field)
    );

    vtg_pulses #(
        .H525(H525), .H625(H625), .HACT_START(HACT_START),
        .HACT_LEN(HACT_LEN), .VDW(VDW)
    ) u_pls (
        .clk(clk), .rst_n(rst_n), .std_625(std_625),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .qidx(qidx),
        .v_act(v_act), .field(field),
        .hd_phase(hd_phase), .hd_width(hd_width), .hd_pol(hd_pol),
        .vd_phase(vd_phase), .vd_width(vd_width), .vd_pol(vd_pol),
        .fld_inv(fld_inv), .cbcr_inv(cbcr_inv), .nosig_in(nosig_in),
        .pulse_q(pulse_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pin_out[i] = pulse_q[pin_sel[3*i +: 3]];
    end

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
    parameter int HW         = 11,
    parameter int QW         = 9,
    parameter int HACT_START = 264,
    parameter int HACT_LEN   = 1440,
    parameter int VDW        = 6,
    parameter int NPINS      = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    std_625,
    input logic [vtg_pkg::QPW-1:0] vd_phase,
    input logic [VDW-1:0]          vd_width,
    input logic                    vd_pol,
    input logic                    nosig_in,
    input logic [3*NPINS-1:0]      pin_sel,
    input logic [NPINS-1:0]        pin_out,
    input logic [HW-1:0]           h_cnt,
    input logic [QW-1:0]           qsub,
    input logic [1:0]              qidx,
    input vtg_pkg::vstate_t        state,
    input logic [7:0]              pulse_q
);
    localparam logic [HW-1:0] LO = HW'(HACT_START);
    localparam logic [HW-1:0] HI = HW'(HACT_START + HACT_LEN);

    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_quarter_align: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == '0) |-> (qsub == '0 && qidx == 2'd0));

    a_r6_state_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && state != $past(state)) |-> (h_cnt == '0));

    a_r2_de_in_hwindow: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pulse_q[1]) |-> ($past(h_cnt) >= LO && $past(h_cnt) < HI));

    a_r4_vd_quarter_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $stable(vd_pol) && $stable(vd_phase) && $stable(vd_width) &&
         $stable(std_625) && pulse_q[3] != $past(pulse_q[3])) |-> ($past(qsub) == '0));

    a_r8_nosig_route: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pin_sel[2:0] == 3'd6) |-> (pin_out[0] == $past(nosig_in)));

endmodule

bind vtg_top vtg_chk #(
    .HW(HW), .QW(QW), .HACT_START(HACT_START), .HACT_LEN(HACT_LEN),
    .VDW(VDW), .NPINS(NPINS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .std_625(std_625),
    .vd_phase(vd_phase), .vd_width(vd_width), .vd_pol(vd_pol),
    .nosig_in(nosig_in), .pin_sel(pin_sel), .pin_out(pin_out),
    .h_cnt(h_cnt), .qsub(qsub), .qidx(qidx), .state(state), .pulse_q(pulse_q)
);

// File: tb/vtg_top_tb.sv
`timescale 1ns/1ps
module vtg_top_tb;
    localparam int H5 = 16, H6 = 20, HS = 4, HL = 8, NP = 6;
    localparam int HW = $clog2(20);

    logic clk = 1'b0, rst_n = 1'b0, std_625 = 1'b0;
    logic hd_pol = 1'b0, vd_pol = 1'b0, fld_inv = 1'b0, cbcr_inv = 1'b0, nosig_in = 1'b0;
    logic [HW-1:0] hd_phase = '0, hd_width = '0;
    logic [11:0] vd_phase = '0;
    logic [5:0] vd_width = '0;
    logic [3*NP-1:0] pin_sel = '0;
    logic [NP-1:0] pin_out;
    int n_checks = 0, n_fail = 0;

    vtg_top #(.H525(H5), .H625(H6), .HACT_START(HS), .HACT_LEN(HL), .VDW(6), .NPINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .std_625(std_625),
        .hd_phase(hd_phase), .hd_width(hd_width), .hd_pol(hd_pol),
        .vd_phase(vd_phase), .vd_width(vd_width), .vd_pol(vd_pol),
        .fld_inv(fld_inv), .cbcr_inv(cbcr_inv), .nosig_in(nosig_in),
        .pin_sel(pin_sel), .pin_out(pin_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic string req_of(input int code);
        case (code)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [17:0] mk_sel(input int c0, c1, c2, c3, c4, c5);
        return {3'(c5), 3'(c4), 3'(c3), 3'(c2), 3'(c1), 3'(c0)};
    endfunction

    function automatic logic exp_bit(input int code, input int p);
        int ht, nl, h, l, q, vw, f2, a1s, a1e, a2s, a2e;
        logic r;
        ht = std_625 ? H6 : H5;
        nl = std_625 ? 625 : 525;
        if (std_625) begin a1s = 23; a1e = 311; f2 = 313; a2s = 336; a2e = 624; end
        else         begin a1s = 20; a1e = 260; f2 = 263; a2s = 283; a2e = 523; end
        h = p % ht;
        l = (p / ht) % nl;
        q = (p / (ht / 4)) % (4 * nl);
        vw = (vd_width == 0) ? (std_625 ? 10 : 12) : int'(vd_width);
        case (code)
            0: r = 1'b0;
            1: r = ((l >= a1s && l < a1e) || (l >= a2s && l < a2e)) && h >= HS && h < HS + HL;
            2: r = (((h - int'(hd_phase) + ht) % ht) < int'(hd_width)) ^ hd_pol;
            3: r = (((q - int'(vd_phase) + 4 * nl) % (2 * nl)) < vw) ^ vd_pol;
            4: r = (l >= f2) ^ fld_inv;
            5: r = (((h + HS) % 2) == 0) ^ cbcr_inv;
            6: r = nosig_in;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

    task automatic run_frame(input string tag);
        int ht, nl, frame, len, de_pin, vd_pin, c1, c2, vcyc, vw, f2, act, p, code;
        int mism[NP];
        int fpos[NP];
        int fgot[NP];
        int fexp[NP];
        ht = std_625 ? H6 : H5;
        nl = std_625 ? 625 : 525;
        f2 = std_625 ? 313 : 263;
        act = std_625 ? 288 : 240;
        vw = (vd_width == 0) ? (std_625 ? 10 : 12) : int'(vd_width);
        frame = ht * nl;
        len = frame + 3 * ht;   // R1: runs past the frame wrap
        de_pin = -1; vd_pin = -1;
        c1 = 0; c2 = 0; vcyc = 0;
        for (int i = 0; i < NP; i++) begin
            mism[i] = 0; fpos[i] = 0; fgot[i] = 0; fexp[i] = 0;
            if (int'(pin_sel[3*i +: 3]) == 1) de_pin = i;
            if (int'(pin_sel[3*i +: 3]) == 3) vd_pin = i;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            code = int'(pin_sel[3*i +: 3]);
            chk("R1", $sformatf("%s reset level pin%0d", tag, i), int'(pin_out[i]), (code == 7) ? 1 : 0);
        end
        rst_n = 1'b1;
        for (int n = 1; n <= len; n++) begin
            @(negedge clk);
            p = n - 1;
            for (int i = 0; i < NP; i++) begin
                code = int'(pin_sel[3*i +: 3]);
                if (pin_out[i] !== exp_bit(code, p)) begin
                    if (mism[i] == 0) begin
                        fpos[i] = p; fgot[i] = int'(pin_out[i]); fexp[i] = int'(exp_bit(code, p));
                    end
                    mism[i]++;
                end
            end
            if (p < frame) begin
                if (de_pin >= 0 && (p % ht) == HS && pin_out[de_pin]) begin
                    if (((p / ht) % nl) < f2) c1++;
                    else c2++;
                end
                if (vd_pin >= 0 && pin_out[vd_pin] != vd_pol) vcyc++;
            end
        end
        for (int i = 0; i < NP; i++) begin
            code = int'(pin_sel[3*i +: 3]);
            chk(req_of(code), $sformatf("%s pin%0d code%0d mismatches (first p=%0d got %0d exp %0d)",
                tag, i, code, fpos[i], fgot[i], fexp[i]), mism[i], 0);
        end
        if (de_pin >= 0) begin
            chk("R2", $sformatf("%s field1 DE lines", tag), c1, act);
            chk("R2", $sformatf("%s field2 DE lines", tag), c2, act);
        end
        if (vd_pin >= 0)
            chk("R5", $sformatf("%s VD active cycles per frame", tag), vcyc, 2 * vw * (ht / 4));
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // 525 mode, standard VD width, all pulses routed, no-signal set
        std_625 = 0; hd_phase = 2; hd_width = 3; hd_pol = 0;
        vd_phase = 0; vd_width = 0; vd_pol = 0; fld_inv = 0; cbcr_inv = 0; nosig_in = 1;
        pin_sel = mk_sel(1, 2, 3, 4, 5, 6);
        run_frame("525 default");

        // 625 mode, standard 2.5-line VD width
        std_625 = 1; nosig_in = 0;
        run_frame("625 default");

        // 525 mode, all polarities inverted, HD and VD spans crossing the wrap
        std_625 = 0; hd_phase = HW'(H5 - 2); hd_width = 5; hd_pol = 1;
        vd_phase = 12'(4 * 524 + 2); vd_width = 7; vd_pol = 1; fld_inv = 1; cbcr_inv = 1;
        pin_sel = mk_sel(3, 2, 4, 5, 0, 7);
        run_frame("525 inverted");

        // 625 mode, narrow pulses, mid-line VD phase, reversed routing
        std_625 = 1; hd_phase = 0; hd_width = 1; hd_pol = 0;
        vd_phase = 3; vd_width = 1; vd_pol = 0; fld_inv = 0; cbcr_inv = 0; nosig_in = 1;
        pin_sel = mk_sel(6, 5, 4, 3, 2, 1);
        run_frame("625 narrow");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule